// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves a processor core from the frequency code and voltage code it is running at to a requested pair. It works in three phases that always run in the same order. Phase 1 raises the voltage, plus an extra ramp margin. Phase 2 walks the frequency through allowed intermediate codes. Phase 3 writes the final voltage code.

Every change goes out as one strobed write on a control interface that carries both codes. After each write the block polls a change-pending flag on the status interface. It then checks that the status reports exactly what was written, and waits a settling time before the next step. A numerically lower voltage code means a higher voltage, with code 0 at 1.550 V and code 0x1E at 0.800 V.

A requester sets the requested codes and the transition settings, then pulses `start`. It gets back a one-cycle `done` or `error` pulse. The settings are the ramp offset, the voltage step exponent, the relief-time exponent, the stabilization count and the maximum-voltage code.

Top module: `vf_sequencer`

## Requirements
- R1: When `start` is pulsed and the status pair already equals the requested pair, `done` pulses and no write strobe is issued.
- R2: Writes come in strict phase order. First come voltage-only writes, where the FID field equals the current FID. Next come frequency-only writes, where the VID field equals the current VID. Last comes at most one voltage write of the requested VID. After that a final check compares both status codes with the request.
- R3: Phase 1 first clamps the target VID to be no lower than `maxVolt`. It then lowers the VID code by at most 2^`stepExp` per write until it reaches the clamped target.
- R4: After stepping down, phase 1 makes up to `rampOffset` further single-code decrements. The count is doubled when both the start FID and the requested FID are below LOW_TOP (default 6). The decrements stop early once the VID code equals `maxVolt`.
- R5: A FID below HI_BOT (default 8) maps to a VCO code of 8 + 2·FID; any other FID maps to itself. While the VCO distance to the request is above 2, the FID steps by 1 if odd and by 2 if even, in the direction of the request. Going upward from a FID at or below LOW_TOP, it jumps instead to that FID's VCO code + 2. After the stepping, the requested FID is written.
- R6: When both the current and the requested FID are at or below LOW_TOP, phase 2 is a single direct write of the requested FID.
- R7: After each phase-1 voltage write the block waits `stabCount`·20 µs before the next write. After each FID write it waits 2^`reliefExp`·10 µs. The microsecond is TICKS_PER_US clock cycles.
- R8: After a write, the status must report the written code, and the other code must be unchanged. Otherwise `error` pulses and no further write follows.
- R9: While `stsPending` is high the block polls once per cycle. After POLL_LIMIT polls it re-issues the same write. After RETRY_LIMIT strobes of that write without success it pulses `error`.
- R10: `done` and `error` are single-cycle pulses, never high together. `busy` is high from the cycle after `start` until the pulse.
- R11: After reset, `wrStrobe`, `done`, `error` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transition (ignored while busy) |
| reqFid | input | FID_W | Requested frequency code |
| reqVid | input | VID_W | Requested voltage code |
| rampOffset | input | 2 | Extra single-code voltage decrements |
| stepExp | input | 2 | Maximum voltage step is 2^stepExp codes |
| reliefExp | input | 2 | FID settle time is 2^reliefExp · 10 µs |
| stabCount | input | STAB_W | VID settle time in 20 µs units |
| maxVolt | input | VID_W | Highest-voltage (lowest) VID code allowed in phase 1 |
| stsFid | input | FID_W | Current FID reported by the core |
| stsVid | input | VID_W | Current VID reported by the core |
| stsPending | input | 1 | Change still in progress |
| wrStrobe | output | 1 | One-cycle control write |
| wrFid | output | FID_W | FID field of the control write |
| wrVid | output | VID_W | VID field of the control write |
| busy | output | 1 | Transition in progress |
| done | output | 1 | Transition finished successfully (pulse) |
| error | output | 1 | Transition aborted (pulse) |

## Verification
The hardest state to reach from the ports is the re-issue path. A write has to stay pending for longer than the poll limit and then go through on a later strobe. The bench's core model holds the pending flag high for a chosen number of initial writes, until the next strobe arrives. With the poll and retry limits lowered through parameters, this drives both the recovery and the hard-error outcome. A second fault mode in the model corrupts the voltage code after a frequency write, which reaches the readback abort.

// File: rtl/vfseq_pkg.sv
package vfseq_pkg;

  typedef enum logic [2:0] {
    WK_DOWN,
    WK_RAMP,
    WK_FSTEP,
    WK_FFINAL,
    WK_VFINAL
  } wrKind_e;

  typedef struct packed {
    logic latchReq;
    logic loadDown;
    logic loadRamp;
    logic clrRamp;
    logic loadFStep;
    logic loadFFinal;
    logic loadVFinal;
    logic issueWrite;
    logic pollTick;
    logic bumpRetry;
    logic capture;
    logic loadVst;
    logic loadIrt;
    logic delayTick;
  } ctrlStrobes_t;

  typedef struct packed {
    logic pairMatch;
    logic needDown;
    logic rampGo;
    logic atMax;
    logic fidSame;
    logic fidLoop;
    logic vidFinalNeed;
    logic pollExpired;
    logic retryExpired;
    logic writeOk;
    logic delayZero;
    logic finalOk;
  } dpFlags_t;

endpackage

// File: rtl/vfseq_dpath.sv
module vfseq_dpath
  import vfseq_pkg::*;
#(
  parameter int FID_W        = 6,
  parameter int VID_W        = 5,
  parameter int STAB_W       = 8,
  parameter int LOW_TOP      = 6,
  parameter int HI_BOT       = 8,
  parameter int TICKS_PER_US = 200,
  parameter int POLL_LIMIT   = 10000,
  parameter int RETRY_LIMIT  = 100
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       st,
  input  logic [FID_W-1:0]   reqFid,
  input  logic [VID_W-1:0]   reqVid,
  input  logic [1:0]         rampOffset,
  input  logic [1:0]         stepExp,
  input  logic [1:0]         reliefExp,
  input  logic [STAB_W-1:0]  stabCount,
  input  logic [VID_W-1:0]   maxVolt,
  input  logic [FID_W-1:0]   stsFid,
  input  logic [VID_W-1:0]   stsVid,
  output dpFlags_t           fl,
  output logic               wrStrobe,
  output logic [FID_W-1:0]   wrFid,
  output logic [VID_W-1:0]   wrVid
);

  localparam int VCO_W   = FID_W + 1;
  localparam int DLY_W   = 32;
  localparam int POLL_W  = $clog2(POLL_LIMIT);
  localparam int RETRY_W = (RETRY_LIMIT > 1) ? $clog2(RETRY_LIMIT) : 1;
  localparam logic [FID_W-1:0] LOW_C = FID_W'(LOW_TOP);
  localparam logic [FID_W-1:0] HIB_C = FID_W'(HI_BOT);
  localparam logic [DLY_W-1:0] VST_UNIT = DLY_W'(20 * TICKS_PER_US);
  localparam logic [DLY_W-1:0] IRT_UNIT = DLY_W'(10 * TICKS_PER_US);

  function automatic logic [VCO_W-1:0] toVco(input logic [FID_W-1:0] f);
    if (f < HIB_C) return VCO_W'(8) + {f, 1'b0};
    else           return {1'b0, f};
  endfunction

  // latched request and settings
  logic [FID_W-1:0]  rqFid, curFid, tgtFid;
  logic [VID_W-1:0]  rqVid, clampVid, curVid, tgtVid, maxVQ;
  logic [1:0]        stepQ, reliefQ;
  logic [STAB_W-1:0] stabQ;
  logic [2:0]        rampLeft, rampTotal;
  logic [DLY_W-1:0]  delayCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [RETRY_W-1:0] retryCnt;

  // start-time decisions
  logic             lowBothIn;
  logic [2:0]       rampIn;
  logic [VID_W-1:0] clampIn;
  assign lowBothIn = (stsFid < LOW_C) && (reqFid < LOW_C);
  assign rampIn    = lowBothIn ? {rampOffset, 1'b0} : {1'b0, rampOffset};
  assign clampIn   = (reqVid < maxVolt) ? maxVolt : reqVid;

  // phase 1 arithmetic
  logic [VID_W:0]   stepSize, vidGap, rampSum;
  logic [VID_W-1:0] downTarget;
  assign stepSize   = (VID_W+1)'(1) << stepQ;
  assign vidGap     = {1'b0, curVid} - {1'b0, clampVid};
  assign downTarget = (vidGap > stepSize) ? (curVid - stepSize[VID_W-1:0]) : clampVid;
  assign rampSum    = (VID_W+1)'(rampTotal) + {1'b0, curVid};

  // phase 2 arithmetic
  logic [VCO_W-1:0] vcoCur, vcoReq, vcoDiff;
  logic [FID_W-1:0] interval, stepFid;
  logic             lowBothP2;
  assign vcoCur    = toVco(curFid);
  assign vcoReq    = toVco(rqFid);
  assign vcoDiff   = (vcoCur > vcoReq) ? (vcoCur - vcoReq) : (vcoReq - vcoCur);
  assign lowBothP2 = (rqFid <= LOW_C) && (curFid <= LOW_C);
  assign interval  = curFid[0] ? FID_W'(1) : FID_W'(2);
  always_comb begin
    if (rqFid > curFid) begin
      if (curFid > LOW_C) stepFid = curFid + interval;
      else                stepFid = vcoCur[FID_W-1:0] + FID_W'(2);
    end else begin
      stepFid = curFid - interval;
    end
  end

  // settle-time loads
  logic [DLY_W-1:0] vstLoad, irtLoad;
  assign vstLoad = DLY_W'(stabQ) * VST_UNIT;
  assign irtLoad = (DLY_W'(1) << reliefQ) * IRT_UNIT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rqFid <= '0; rqVid <= '0; clampVid <= '0; maxVQ <= '0;
      curFid <= '0; curVid <= '0; tgtFid <= '0; tgtVid <= '0;
      stepQ <= '0; reliefQ <= '0; stabQ <= '0;
      rampLeft <= '0; rampTotal <= '0;
    end else begin
      if (st.latchReq) begin
        rqFid     <= reqFid;
        rqVid     <= reqVid;
        clampVid  <= clampIn;
        maxVQ     <= maxVolt;
        stepQ     <= stepExp;
        reliefQ   <= reliefExp;
        stabQ     <= stabCount;
        curFid    <= stsFid;
        curVid    <= stsVid;
        rampLeft  <= rampIn;
        rampTotal <= rampIn;
      end
      if (st.capture) begin
        curFid <= stsFid;
        curVid <= stsVid;
      end
      if (st.loadDown) begin
        tgtFid <= curFid; tgtVid <= downTarget;
      end
      if (st.loadRamp) begin
        tgtFid <= curFid; tgtVid <= curVid - VID_W'(1);
        rampLeft <= rampLeft - 3'd1;
      end
      if (st.clrRamp) rampLeft <= '0;
      if (st.loadFStep) begin
        tgtFid <= stepFid; tgtVid <= curVid;
      end
      if (st.loadFFinal) begin
        tgtFid <= rqFid; tgtVid <= curVid;
      end
      if (st.loadVFinal) begin
        tgtFid <= curFid; tgtVid <= rqVid;
      end
    end
  end

  logic anyLoad;
  assign anyLoad = st.loadDown | st.loadRamp | st.loadFStep | st.loadFFinal | st.loadVFinal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayCnt <= '0;
      pollCnt  <= '0;
      retryCnt <= '0;
    end else begin
      if (st.loadVst)        delayCnt <= vstLoad;
      else if (st.loadIrt)   delayCnt <= irtLoad;
      else if (st.delayTick) delayCnt <= delayCnt - DLY_W'(1);
      if (st.issueWrite)     pollCnt <= '0;
      else if (st.pollTick)  pollCnt <= pollCnt + POLL_W'(1);
      if (anyLoad)           retryCnt <= '0;
      else if (st.bumpRetry) retryCnt <= retryCnt + RETRY_W'(1);
    end
  end

  assign fl.pairMatch    = (stsFid == reqFid) && (stsVid == reqVid);
  assign fl.needDown     = curVid > clampVid;
  assign fl.rampGo       = (rampLeft != 3'd0) && (rampSum > {1'b0, clampVid});
  assign fl.atMax        = curVid <= maxVQ;
  assign fl.fidSame      = curFid == rqFid;
  assign fl.fidLoop      = !lowBothP2 && (vcoDiff > VCO_W'(2));
  assign fl.vidFinalNeed = curVid != rqVid;
  assign fl.pollExpired  = pollCnt == POLL_W'(POLL_LIMIT - 1);
  assign fl.retryExpired = retryCnt == RETRY_W'(RETRY_LIMIT - 1);
  assign fl.writeOk      = (curFid == tgtFid) && (curVid == tgtVid);
  assign fl.delayZero    = delayCnt == '0;
  assign fl.finalOk      = (curFid == rqFid) && (curVid == rqVid);

  assign wrStrobe = st.issueWrite;
  assign wrFid    = tgtFid;
  assign wrVid    = tgtVid;

  // R3: a down-step never overshoots the clamp nor exceeds the step size
  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.loadDown |=> ((curVid - tgtVid) <= stepSize[VID_W-1:0]) && (tgtVid >= clampVid));

  // R3: the phase-1 target is never below the maximum-voltage code
  assert_clamp_R3: assert property (@(posedge clk) disable iff (!rstN)
    clampVid >= maxVQ);

  // R4: ramp writes move exactly one code toward higher voltage
  assert_ramp_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    st.loadRamp |=> (tgtVid == curVid - VID_W'(1)) && (tgtFid == curFid));

  // R9: the retry counter stays inside its window
  assert_retry_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RETRY_W'(RETRY_LIMIT - 1));

endmodule

// File: rtl/vfseq_ctrl.sv
module vfseq_ctrl
  import vfseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         stsPending,
  input  dpFlags_t     fl,
  output ctrlStrobes_t st,
  output logic         busy,
  output logic         done,
  output logic         error
);

  typedef enum logic [3:0] {
    S_IDLE, S_P1DOWN, S_P1RAMP, S_P2ENTRY, S_P2LOOP, S_P3,
    S_WR, S_POLL, S_CHECK, S_WAIT, S_FINAL, S_ERR
  } state_e;

  state_e  state, nxt;
  wrKind_e kind, nxtKind;

  always_comb begin
    st      = '0;
    nxt     = state;
    nxtKind = kind;
    case (state)
      S_IDLE: if (start) begin
        st.latchReq = 1'b1;
        nxt = fl.pairMatch ? S_FINAL : S_P1DOWN;
      end
      S_P1DOWN: begin
        if (fl.needDown) begin
          st.loadDown = 1'b1; nxtKind = WK_DOWN; nxt = S_WR;
        end else begin
          nxt = S_P1RAMP;
        end
      end
      S_P1RAMP: begin
        if (!fl.rampGo)   nxt = S_P2ENTRY;
        else if (fl.atMax) st.clrRamp = 1'b1;
        else begin
          st.loadRamp = 1'b1; nxtKind = WK_RAMP; nxt = S_WR;
        end
      end
      S_P2ENTRY: nxt = fl.fidSame ? S_P3 : S_P2LOOP;
      S_P2LOOP: begin
        nxt = S_WR;
        if (fl.fidLoop) begin
          st.loadFStep = 1'b1; nxtKind = WK_FSTEP;
        end else begin
          st.loadFFinal = 1'b1; nxtKind = WK_FFINAL;
        end
      end
      S_P3: begin
        if (fl.vidFinalNeed) begin
          st.loadVFinal = 1'b1; nxtKind = WK_VFINAL; nxt = S_WR;
        end else begin
          nxt = S_FINAL;
        end
      end
      S_WR: begin
        st.issueWrite = 1'b1;
        nxt = S_POLL;
      end
      S_POLL: begin
        if (!stsPending) begin
          st.capture = 1'b1; nxt = S_CHECK;
        end else if (fl.pollExpired) begin
          if (fl.retryExpired) nxt = S_ERR;
          else begin
            st.bumpRetry = 1'b1; nxt = S_WR;
          end
        end else begin
          st.pollTick = 1'b1;
        end
      end
      S_CHECK: begin
        if (!fl.writeOk) nxt = S_ERR;
        else begin
          case (kind)
            WK_DOWN, WK_RAMP:    begin st.loadVst = 1'b1; nxt = S_WAIT; end
            WK_FSTEP, WK_FFINAL: begin st.loadIrt = 1'b1; nxt = S_WAIT; end
            default:             nxt = S_FINAL;
          endcase
        end
      end
      S_WAIT: begin
        if (!fl.delayZero) st.delayTick = 1'b1;
        else begin
          case (kind)
            WK_DOWN:  nxt = S_P1DOWN;
            WK_RAMP:  nxt = S_P1RAMP;
            WK_FSTEP: nxt = S_P2LOOP;
            WK_FFINAL: nxt = S_P3;
            default:  nxt = S_FINAL;
          endcase
        end
      end
      S_FINAL: nxt = S_IDLE;
      S_ERR:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kind  <= WK_DOWN;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nxt;
      kind  <= nxtKind;
      done  <= (state == S_FINAL) && fl.finalOk;
      error <= ((state == S_FINAL) && !fl.finalOk) || (state == S_ERR);
    end
  end

  assign busy = state != S_IDLE;

  // R10: completion outputs are one-cycle pulses and exclusive
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_error_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    error |=> !error);
  assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

endmodule

// File: rtl/vf_sequencer.sv
module vf_sequencer
  import vfseq_pkg::*;
#(
  parameter int FID_W        = 6,
  parameter int VID_W        = 5,
  parameter int STAB_W       = 8,
  parameter int LOW_TOP      = 6,
  parameter int HI_BOT       = 8,
  parameter int TICKS_PER_US = 200,
  parameter int POLL_LIMIT   = 10000,
  parameter int RETRY_LIMIT  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FID_W-1:0]  reqFid,
  input  logic [VID_W-1:0]  reqVid,
  input  logic [1:0]        rampOffset,
  input  logic [1:0]        stepExp,
  input  logic [1:0]        reliefExp,
  input  logic [STAB_W-1:0] stabCount,
  input  logic [VID_W-1:0]  maxVolt,
  input  logic [FID_W-1:0]  stsFid,
  input  logic [VID_W-1:0]  stsVid,
  input  logic              stsPending,
  output logic              wrStrobe,
  output logic [FID_W-1:0]  wrFid,
  output logic [VID_W-1:0]  wrVid,
  output logic              busy,
  output logic              done,
  output logic              error
);

  ctrlStrobes_t strobes;
  dpFlags_t     flags;

  vfseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stsPending(stsPending),
    .fl(flags), .st(strobes), .busy(busy), .done(done), .error(error)
  );

  vfseq_dpath #(
    .FID_W(FID_W), .VID_W(VID_W), .STAB_W(STAB_W),
    .LOW_TOP(LOW_TOP), .HI_BOT(HI_BOT), .TICKS_PER_US(TICKS_PER_US),
    .POLL_LIMIT(POLL_LIMIT), .RETRY_LIMIT(RETRY_LIMIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .st(strobes),
    .reqFid(reqFid), .reqVid(reqVid), .rampOffset(rampOffset),
    .stepExp(stepExp), .reliefExp(reliefExp), .stabCount(stabCount),
    .maxVolt(maxVolt), .stsFid(stsFid), .stsVid(stsVid),
    .fl(flags), .wrStrobe(wrStrobe), .wrFid(wrFid), .wrVid(wrVid)
  );

endmodule

// File: tb/vf_sequencer_bench.sv
`timescale 1ns/1ps
module vf_sequencer_bench;
  localparam int LOWT = 6;
  localparam int HIB  = 8;
  localparam int TPU  = 2;
  localparam int PL   = 16;
  localparam int RL   = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, start = 1'b0;
  logic [5:0] reqFid = '0;
  logic [4:0] reqVid = '0, maxVolt = '0;
  logic [1:0] rampOffset = '0, stepExp = '0, reliefExp = '0;
  logic [7:0] stabCount = '0;
  logic [5:0] pF = '0, hF = '0;
  logic [4:0] pV = '0, hV = '0;
  logic pend = 1'b0, stuckNow = 1'b0, hFidW = 1'b0;
  logic wrStrobe, busy, done, error;
  logic [5:0] wrFid;
  logic [4:0] wrVid;

  vf_sequencer #(.LOW_TOP(LOWT), .HI_BOT(HIB), .TICKS_PER_US(TPU),
                 .POLL_LIMIT(PL), .RETRY_LIMIT(RL)) u_vf_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .reqFid(reqFid), .reqVid(reqVid),
    .rampOffset(rampOffset), .stepExp(stepExp), .reliefExp(reliefExp),
    .stabCount(stabCount), .maxVolt(maxVolt), .stsFid(pF), .stsVid(pV),
    .stsPending(pend), .wrStrobe(wrStrobe), .wrFid(wrFid), .wrVid(wrVid),
    .busy(busy), .done(done), .error(error));

  // behavioural core model: pending for a few cycles, then status updates
  int stuckN = 0;
  bit corrupt = 1'b0;
  logic presetGo = 1'b0;
  logic [5:0] presetF = '0;
  logic [4:0] presetV = '0;
  int pCnt = 0, wrIdx = 0;
  always @(posedge clk) begin
    if (presetGo) begin
      pF <= presetF; pV <= presetV; pend <= 1'b0; wrIdx <= 0; stuckNow <= 1'b0;
    end else if (wrStrobe) begin
      pend <= 1'b1; hF <= wrFid; hV <= wrVid; hFidW <= (wrFid != pF);
      pCnt <= 2; stuckNow <= (wrIdx < stuckN); wrIdx <= wrIdx + 1;
    end else if (pend && !stuckNow) begin
      if (pCnt == 0) begin
        pend <= 1'b0; pF <= hF;
        pV <= (corrupt && hFidW) ? (hV ^ 5'd1) : hV;
      end else pCnt <= pCnt - 1;
    end
  end

  // expected write stream
  int eF[64], eV[64], eG[64];
  int eN = 0;
  string curTag = "R2";

  // monitor: compares every strobe, on every falling edge
  int cyc = 0, mIdx = 0, mLast = 0, mGap = 0, mChk = 0, mBad = 0;
  int doneCnt = 0, errCnt = 0;
  bit mHave = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (start) begin mIdx = 0; mHave = 1'b0; end
    if (rstN && wrStrobe) begin
      mChk++;
      if (mIdx >= eN) begin
        mBad++;
        $display("FAIL %s: extra write fid=%0d vid=%0d, expected only %0d writes", curTag, wrFid, wrVid, eN);
      end else begin
        if (wrFid != eF[mIdx] || wrVid != eV[mIdx]) begin
          mBad++;
          $display("FAIL %s: write %0d got fid=%0d vid=%0d, expected fid=%0d vid=%0d",
                   curTag, mIdx, wrFid, wrVid, eF[mIdx], eV[mIdx]);
        end
        if (mHave) begin
          mChk++;
          if (cyc - mLast < mGap) begin
            mBad++;
            $display("FAIL R7: gap before write %0d was %0d cycles, expected at least %0d", mIdx, cyc - mLast, mGap);
          end
        end
        mGap = eG[mIdx]; mLast = cyc; mHave = 1'b1; mIdx++;
      end
    end
    if (rstN && done)  doneCnt++;
    if (rstN && error) errCnt++;
  end

  int chk = 0, bad = 0;

  task automatic check(string tag, int act, int exp, string what);
    chk++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int vco(int f);
    return (f < HIB) ? 8 + 2 * f : f;
  endfunction

  task automatic push(int f, int v, int g);
    eF[eN] = f; eV[eN] = v; eG[eN] = g; eN++;
  endtask

  task automatic gen(int cf, int cv, int rf, int rv, int rvo, int mvs, int irt, int stab, int mx);
    int v, f, clampV, mult, steps, vst, irtc, d, iv, n;
    eN = 0;
    if (cf == rf && cv == rv) return;
    vst = stab * 20 * TPU;
    irtc = (1 << irt) * 10 * TPU;
    clampV = (rv < mx) ? mx : rv;
    mult = (cf < LOWT && rf < LOWT) ? 2 : 1;
    steps = rvo * mult;
    v = cv; f = cf;
    while (v > clampV) begin
      n = (v - clampV > (1 << mvs)) ? v - (1 << mvs) : clampV;
      push(f, n, vst); v = n;
    end
    while (steps > 0 && (mult * rvo + v) > clampV) begin
      if (v == mx) steps = 0;
      else begin push(f, v - 1, vst); v--; steps--; end
    end
    if (f != rf) begin
      if (!(rf <= LOWT && f <= LOWT)) begin
        d = vco(f) - vco(rf); if (d < 0) d = -d;
        while (d > 2) begin
          iv = (f % 2 == 1) ? 1 : 2;
          if (rf > f) n = (f > LOWT) ? f + iv : vco(f) + 2;
          else n = f - iv;
          push(n, v, irtc); f = n;
          d = vco(f) - vco(rf); if (d < 0) d = -d;
        end
      end
      push(rf, v, irtc); f = rf;
    end
    if (v != rv) push(f, rv, 0);
  endtask

  task automatic drv();
    @(posedge clk); #1;
  endtask

  // mode: 0 normal, 1 retry then succeed, 2 stuck forever, 3 corrupt readback
  task automatic runCase(string tag, int cf, int cv, int rf, int rv, int rvo, int mvs,
                         int irt, int stab, int mx, int mode);
    int d0, e0, k;
    bit fin;
    curTag = tag;
    gen(cf, cv, rf, rv, rvo, mvs, irt, stab, mx);
    if (mode == 1) begin
      for (int i = eN - 1; i >= 0; i--) begin eF[i+2] = eF[i]; eV[i+2] = eV[i]; eG[i+2] = eG[i]; end
      for (int i = 0; i < 2; i++) begin eF[i] = eF[2]; eV[i] = eV[2]; eG[i] = 0; end
      eN += 2;
    end else if (mode == 2) begin
      for (int i = 0; i < RL; i++) begin eF[i] = eF[0]; eV[i] = eV[0]; eG[i] = 0; end
      eN = RL;
    end else if (mode == 3) begin
      k = 0;
      for (int i = 0; i < eN; i++) begin
        if (eF[i] != ((i == 0) ? cf : eF[i-1])) begin k = i; break; end
      end
      eN = k + 1;
    end
    drv();
    presetF = 6'(cf); presetV = 5'(cv); presetGo = 1'b1;
    stuckN = (mode == 1) ? 2 : (mode == 2) ? 1000 : 0;
    corrupt = (mode == 3);
    drv();
    presetGo = 1'b0;
    reqFid = 6'(rf); reqVid = 5'(rv); rampOffset = 2'(rvo); stepExp = 2'(mvs);
    reliefExp = 2'(irt); stabCount = 8'(stab); maxVolt = 5'(mx);
    d0 = doneCnt; e0 = errCnt;
    drv();
    start = 1'b1;
    drv();
    start = 1'b0;
    check("R10", int'(busy), 1, {tag, " busy during run"});
    fin = 1'b0;
    for (int i = 0; i < 20000 && !fin; i++) begin
      @(posedge clk);
      if (doneCnt != d0 || errCnt != e0) fin = 1'b1;
    end
    for (int i = 0; i < 6; i++) @(posedge clk);
    #1;
    if (mode >= 2) begin
      check(tag, errCnt - e0, 1, "error pulses");
      check(tag, doneCnt - d0, 0, "done pulses");
    end else begin
      check("R10", doneCnt - d0, 1, {tag, " done pulses"});
      check("R10", errCnt - e0, 0, {tag, " error pulses"});
    end
    check(tag, mIdx, eN, "write strobes issued");
    check("R10", int'(busy), 0, {tag, " busy after completion"});
  endtask

  initial begin
    #(150000 * 5);
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", chk + mChk + 1, bad + mBad + 1);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    repeat (4) drv();
    check("R11", int'(wrStrobe), 0, "wrStrobe in reset");
    check("R11", int'(busy), 0, "busy in reset");
    rstN = 1'b1;
    drv();
    check("R11", int'(done), 0, "done after reset");
    check("R11", int'(error), 0, "error after reset");
    check("R11", int'(busy), 0, "busy after reset");

    runCase("R1", 10, 16, 10, 16, 1, 1, 0, 1, 2, 0);
    runCase("R3", 10, 18, 14, 10, 1, 1, 0, 1, 2, 0);
    runCase("R2", 12, 8, 0, 20, 2, 0, 1, 0, 2, 0);
    runCase("R5", 0, 16, 16, 6, 1, 2, 0, 0, 0, 0);
    runCase("R6", 2, 16, 4, 16, 1, 0, 0, 1, 0, 0);
    runCase("R4", 10, 8, 12, 1, 3, 3, 0, 0, 4, 0);
    runCase("R5", 15, 12, 9, 12, 0, 0, 2, 0, 0, 0);
    runCase("R9", 10, 18, 14, 10, 1, 1, 0, 1, 2, 1);
    runCase("R9", 15, 12, 9, 12, 0, 0, 2, 0, 0, 2);
    runCase("R8", 12, 8, 0, 20, 2, 0, 1, 0, 2, 3);
    runCase("R7", 20, 14, 26, 8, 2, 1, 1, 2, 3, 0);

    $display("test done: total=%0d bad=%0d", chk + mChk, bad + mBad);
    $finish;
  end
endmodule